// File: doc/BRIEF.md
# Streaming Tile Matrix Multiplier

This block computes one output tile `C = A x B` of a tiled integer matrix product. Both operand tiles arrive one word at a time on a single valid/ready input stream and are held in on-chip RAM. The tile of A comes first, one row at a time. The tile of B follows, one column at a time.

Once the last operand word has been taken, the block starts on its own. A sequencer walks three nested loops over output row, output column and the shared dimension. It accumulates each dot product in a wide register and writes the truncated result into a local C buffer. The C tile is then sent out, row by row, on a valid/ready output stream.

A `busy` flag covers the whole transaction. A one-cycle `done` pulse marks the end of the transaction, and the block is then ready for the next tile. The tile sizes `ROWS` (rows of C), `COLS` (columns of C) and `DEPTH_K` (the shared dimension) and the word width `DATA_W` are compile-time parameters.

Top module: `tile_mm_engine`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low and `in_ready` is high.
- R2: A tile is exactly ROWS*DEPTH_K + COLS*DEPTH_K accepted words, in this order:
  - ROWS vectors of DEPTH_K words, where vector r carries A(r,0..DEPTH_K-1);
  - then COLS vectors of DEPTH_K words, where vector c carries B(0..DEPTH_K-1,c).
  - `in_ready` drops in the cycle after the final word is accepted.
- R3: Each output word equals the sum over k of A(i,k)*B(k,j), taken modulo 2^DATA_W. Operands are unsigned, and the sum is formed in an accumulator 2*DATA_W+clog2(DEPTH_K) bits wide.
- R4: Exactly ROWS*COLS words leave in row-major order, with element (i,j) at position i*COLS+j. `out_valid` is low after the last of them.
- R5: No start command exists. `out_valid` first rises ROWS*COLS*DEPTH_K clock cycles after the clock edge that accepts the final input word.
- R6: A word moves on either stream only on a clock edge where both its valid and its ready are high. Gaps in `in_valid` and low `out_ready` only delay the result; they do not change it.
- R7: `busy` rises in the cycle after the first input word is accepted. It falls in the cycle after the last output word is accepted.
- R8: `in_ready` stays low through the compute and output phases. Words offered then are not taken and do not alter the result.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the last output word is accepted, and `busy` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand word offered |
| in_ready | output | 1 | Operand word can be taken |
| in_data | input | DATA_W | Operand word |
| out_valid | output | 1 | Result word offered |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | DATA_W | Result word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
Four kinds of operand pattern are used:
- A selector B, with ones on the leading diagonal. It copies columns of A into C, so any error in the output order or in the roles of rows and columns shows as a wrong position.
- All-ones-maximum tiles. They produce products that overflow DATA_W, and so test the modulo truncation.
- Random tiles, run with random input gaps and random output stalls. They check the accumulation sequence against a reference product, and show that flow control never changes the data.
- Garbage words offered while the block computes. They show that nothing is taken in that phase, while the bench also counts the cycles from the final input to the first result.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOAD  = 2'd1,
      PH_CALC  = 2'd2,
      PH_DRAIN = 2'd3
   } tmm_phase_e;

   // Address width for a store of n entries (at least one bit).
   function automatic int unsigned addr_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tmm_ram.sv
module tmm_ram #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/tmm_loader.sv
module tmm_loader
   import tmm_pkg::*;
#(
   parameter int unsigned ROWS    = 4,
   parameter int unsigned COLS    = 3,
   parameter int unsigned DEPTH_K = 5,
   parameter int unsigned AA_W    = 5,
   parameter int unsigned BA_W    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   output logic            a_we,
   output logic            b_we,
   output logic [AA_W-1:0] a_waddr,
   output logic [BA_W-1:0] b_waddr,
   output logic            last
);
   localparam int unsigned A_WORDS = ROWS * DEPTH_K;
   localparam int unsigned TOTAL   = A_WORDS + COLS * DEPTH_K;
   localparam int unsigned IDX_W   = addr_w(TOTAL);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] b_off;
   logic             in_a;

   assign in_a    = idx_q < IDX_W'(A_WORDS);
   assign b_off   = idx_q - IDX_W'(A_WORDS);
   assign a_we    = accept && in_a;
   assign b_we    = accept && !in_a;
   assign a_waddr = AA_W'(idx_q);
   assign b_waddr = BA_W'(b_off);
   assign last    = accept && (idx_q == IDX_W'(TOTAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (last)   idx_q <= '0;
      else if (accept) idx_q <= idx_q + 1'b1;
   end
endmodule

// File: rtl/tmm_sequencer.sv
module tmm_sequencer
   import tmm_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ROWS    = 4,
   parameter int unsigned COLS    = 3,
   parameter int unsigned DEPTH_K = 5,
   parameter int unsigned AA_W    = 5,
   parameter int unsigned BA_W    = 4,
   parameter int unsigned CA_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] a_rdata,
   input  logic [DATA_W-1:0] b_rdata,
   output logic [AA_W-1:0]   a_raddr,
   output logic [BA_W-1:0]   b_raddr,
   output logic              c_we,
   output logic [CA_W-1:0]   c_waddr,
   output logic [DATA_W-1:0] c_wdata,
   output logic              finish
);
   localparam int unsigned ACC_W   = 2 * DATA_W + $clog2(DEPTH_K);
   localparam int unsigned K_W     = addr_w(DEPTH_K);
   localparam int unsigned J_W     = addr_w(COLS);
   localparam int unsigned C_WORDS = ROWS * COLS;

   logic              run_q;
   logic [K_W-1:0]    k_q;
   logic [J_W-1:0]    j_q;
   logic [AA_W-1:0]   a_base_q;
   logic [BA_W-1:0]   b_base_q;
   logic [CA_W-1:0]   c_addr_q;
   logic [ACC_W-1:0]  acc_q;
   logic [2*DATA_W-1:0] prod;
   logic [ACC_W-1:0]  sum;
   logic              k_end, j_end, c_end;

   assign k_end   = k_q == K_W'(DEPTH_K - 1);
   assign j_end   = j_q == J_W'(COLS - 1);
   assign c_end   = c_addr_q == CA_W'(C_WORDS - 1);
   assign a_raddr = a_base_q + AA_W'(k_q);
   assign b_raddr = b_base_q + BA_W'(k_q);
   assign prod    = a_rdata * b_rdata;
   assign sum     = acc_q + ACC_W'(prod);
   assign c_we    = run_q && k_end;
   assign c_waddr = c_addr_q;
   assign c_wdata = sum[DATA_W-1:0];
   assign finish  = c_we && c_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         k_q      <= '0;
         j_q      <= '0;
         a_base_q <= '0;
         b_base_q <= '0;
         c_addr_q <= '0;
         acc_q    <= '0;
      end else if (start) begin
         run_q    <= 1'b1;
         k_q      <= '0;
         j_q      <= '0;
         a_base_q <= '0;
         b_base_q <= '0;
         c_addr_q <= '0;
         acc_q    <= '0;
      end else if (run_q) begin
         if (k_end) begin
            k_q      <= '0;
            acc_q    <= '0;
            c_addr_q <= c_end ? '0 : c_addr_q + 1'b1;
            if (j_end) begin
               j_q      <= '0;
               b_base_q <= '0;
               a_base_q <= a_base_q + AA_W'(DEPTH_K);
            end else begin
               j_q      <= j_q + 1'b1;
               b_base_q <= b_base_q + BA_W'(DEPTH_K);
            end
         end else begin
            k_q   <= k_q + 1'b1;
            acc_q <= sum;
         end
         if (finish) run_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tmm_drain.sv
module tmm_drain #(
   parameter int unsigned ROWS = 4,
   parameter int unsigned COLS = 3,
   parameter int unsigned CA_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            out_ready,
   output logic [CA_W-1:0] c_raddr,
   output logic            last
);
   localparam int unsigned C_WORDS = ROWS * COLS;

   logic [CA_W-1:0] pos_q;
   logic            pop;

   assign pop     = active && out_ready;
   assign last    = pop && (pos_q == CA_W'(C_WORDS - 1));
   assign c_raddr = pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    pos_q <= '0;
      else if (last) pos_q <= '0;
      else if (pop)  pos_q <= pos_q + 1'b1;
   end
endmodule

// File: rtl/tile_mm_engine.sv
module tile_mm_engine
   import tmm_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ROWS    = 4,
   parameter int unsigned COLS    = 3,
   parameter int unsigned DEPTH_K = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              busy,
   output logic              done
);
   localparam int unsigned A_WORDS = ROWS * DEPTH_K;
   localparam int unsigned B_WORDS = COLS * DEPTH_K;
   localparam int unsigned C_WORDS = ROWS * COLS;
   localparam int unsigned AA_W    = addr_w(A_WORDS);
   localparam int unsigned BA_W    = addr_w(B_WORDS);
   localparam int unsigned CA_W    = addr_w(C_WORDS);

   generate
      if (DATA_W < 1 || ROWS < 1 || COLS < 1 || DEPTH_K < 1) begin : g_bad_size
         $error("tile_mm_engine: every size parameter must be at least 1");
      end
      if (2 * DATA_W + $clog2(DEPTH_K) > 128) begin : g_bad_acc
         $error("tile_mm_engine: accumulator wider than 128 bits");
      end
   endgenerate

   tmm_phase_e phase_q;
   logic       done_q;
   logic       take_in;
   logic       load_last, calc_last, drain_last;

   logic              a_we, b_we, c_we;
   logic [AA_W-1:0]   a_waddr, a_raddr;
   logic [BA_W-1:0]   b_waddr, b_raddr;
   logic [CA_W-1:0]   c_waddr, c_raddr;
   logic [DATA_W-1:0] a_rdata, b_rdata, c_wdata, c_rdata;

   assign in_ready  = (phase_q == PH_IDLE) || (phase_q == PH_LOAD);
   assign take_in   = in_valid && in_ready;
   assign out_valid = phase_q == PH_DRAIN;
   assign out_data  = c_rdata;
   assign busy      = phase_q != PH_IDLE;
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= drain_last;
         case (phase_q)
            PH_IDLE:  if (take_in)    phase_q <= PH_LOAD;
            PH_LOAD:  if (load_last)  phase_q <= PH_CALC;
            PH_CALC:  if (calc_last)  phase_q <= PH_DRAIN;
            PH_DRAIN: if (drain_last) phase_q <= PH_IDLE;
            default:                  phase_q <= PH_IDLE;
         endcase
      end
   end

   tmm_loader #(
      .ROWS(ROWS), .COLS(COLS), .DEPTH_K(DEPTH_K), .AA_W(AA_W), .BA_W(BA_W)
   ) u_loader (
      .clk(clk), .rst_n(rst_n), .accept(take_in),
      .a_we(a_we), .b_we(b_we), .a_waddr(a_waddr), .b_waddr(b_waddr),
      .last(load_last)
   );

   tmm_ram #(.W(DATA_W), .DEPTH(A_WORDS), .AW(AA_W)) u_a_ram (
      .clk(clk), .we(a_we), .waddr(a_waddr), .wdata(in_data),
      .raddr(a_raddr), .rdata(a_rdata)
   );

   tmm_ram #(.W(DATA_W), .DEPTH(B_WORDS), .AW(BA_W)) u_b_ram (
      .clk(clk), .we(b_we), .waddr(b_waddr), .wdata(in_data),
      .raddr(b_raddr), .rdata(b_rdata)
   );

   tmm_sequencer #(
      .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS), .DEPTH_K(DEPTH_K),
      .AA_W(AA_W), .BA_W(BA_W), .CA_W(CA_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(load_last),
      .a_rdata(a_rdata), .b_rdata(b_rdata),
      .a_raddr(a_raddr), .b_raddr(b_raddr),
      .c_we(c_we), .c_waddr(c_waddr), .c_wdata(c_wdata),
      .finish(calc_last)
   );

   tmm_ram #(.W(DATA_W), .DEPTH(C_WORDS), .AW(CA_W)) u_c_ram (
      .clk(clk), .we(c_we), .waddr(c_waddr), .wdata(c_wdata),
      .raddr(c_raddr), .rdata(c_rdata)
   );

   tmm_drain #(.ROWS(ROWS), .COLS(COLS), .CA_W(CA_W)) u_drain (
      .clk(clk), .rst_n(rst_n), .active(out_valid), .out_ready(out_ready),
      .c_raddr(c_raddr), .last(drain_last)
   );
endmodule

// File: rtl/tmm_engine_checker.sv
module tmm_engine_checker #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              busy,
   input logic              done
);
   assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_no_input_in_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(in_valid && in_ready));

   assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(out_valid && out_ready));

   assert_idle_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (in_ready && !out_valid));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !out_valid && $fell(busy)));
endmodule

bind tile_mm_engine tmm_engine_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .busy(busy), .done(done)
);

// File: tb/tile_mm_engine_bench.sv
module tile_mm_engine_bench;
   localparam int DATA_W  = 16;
   localparam int ROWS    = 4;
   localparam int COLS    = 3;
   localparam int DEPTH_K = 5;
   localparam int MNK     = ROWS * COLS * DEPTH_K;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic              in_ready;
   logic [DATA_W-1:0] in_data;
   logic              out_valid;
   logic              out_ready;
   logic [DATA_W-1:0] out_data;
   logic              busy;
   logic              done;

   int n_checks = 0;
   int n_fail   = 0;

   logic [DATA_W-1:0] a_t   [ROWS][DEPTH_K];
   logic [DATA_W-1:0] b_t   [DEPTH_K][COLS];
   logic [DATA_W-1:0] got   [ROWS*COLS];

   always #10 clk = ~clk;

   tile_mm_engine #(
      .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS), .DEPTH_K(DEPTH_K)
   ) u_tile_mm_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] ref_elem(input int i, input int j);
      logic [63:0] acc = 0;
      for (int k = 0; k < DEPTH_K; k++) acc += 64'(a_t[i][k]) * 64'(b_t[k][j]);
      return acc[DATA_W-1:0];
   endfunction

   task automatic push_word(input logic [DATA_W-1:0] w, input bit gaps);
      if (gaps) begin
         int idle = int'($urandom % 3);
         in_valid = 1'b0;
         repeat (idle) @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // R2: A rows first, then B columns.
   task automatic load_tile(input bit gaps);
      check(busy == 1'b0, "R7", "busy before first word", 64'(busy), 0);
      for (int i = 0; i < ROWS; i++)
         for (int k = 0; k < DEPTH_K; k++) begin
            push_word(a_t[i][k], gaps);
            if (i == 0 && k == 0)
               check(busy == 1'b1, "R7", "busy after first word", 64'(busy), 1);
         end
      for (int j = 0; j < COLS; j++)
         for (int k = 0; k < DEPTH_K; k++) push_word(b_t[k][j], gaps);
      check(in_ready == 1'b0, "R2", "in_ready after full tile", 64'(in_ready), 0);
   endtask

   task automatic drain(input bit stall);
      int  idx  = 0;
      bit  hold = 0;
      logic [DATA_W-1:0] prev = '0;
      while (idx < ROWS*COLS) begin
         @(negedge clk);
         if (hold) begin
            check(out_valid == 1'b1, "R9", "valid held", 64'(out_valid), 1);
            check(out_data == prev, "R9", "data held", 64'(out_data), 64'(prev));
         end
         out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
         if (out_valid && out_ready) begin
            got[idx] = out_data;
            idx++;
            hold = 0;
         end else begin
            hold = out_valid;
         end
         prev = out_data;
      end
      @(negedge clk);
      out_ready = 1'b0;
      check(done == 1'b1, "R10", "done after last word", 64'(done), 1);
      check(busy == 1'b0, "R7", "busy after last word", 64'(busy), 0);
      check(out_valid == 1'b0, "R4", "valid after last word", 64'(out_valid), 0);
      @(negedge clk);
      check(done == 1'b0, "R10", "done one cycle only", 64'(done), 0);
   endtask

   task automatic run_tile(input string req, input bit gaps, input bit stall,
                           input bit timing);
      load_tile(gaps);
      if (timing) begin
         int cnt = 0;
         in_valid = 1'b1;
         in_data  = 16'hDEAD;
         while (!out_valid && cnt < MNK + 10) begin
            @(negedge clk);
            cnt++;
            check(in_ready == 1'b0, "R8", "in_ready while computing", 64'(in_ready), 0);
         end
         check(cnt == MNK, "R5", "cycles to first result", 64'(cnt), 64'(MNK));
         in_valid = 1'b0;
      end
      drain(stall);
      for (int i = 0; i < ROWS; i++)
         for (int j = 0; j < COLS; j++)
            check(got[i*COLS+j] == ref_elem(i, j), req, $sformatf("C(%0d,%0d)", i, j),
                  64'(got[i*COLS+j]), 64'(ref_elem(i, j)));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_data   = '0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1", "busy in reset", 64'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 0);
      check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
      check(done == 1'b0, "R1", "done after reset", 64'(done), 0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 1);

      // R4: selector B copies A columns, exposing ordering errors; R8 garbage
      for (int i = 0; i < ROWS; i++)
         for (int k = 0; k < DEPTH_K; k++) a_t[i][k] = DATA_W'(16 * i + k + 1);
      for (int k = 0; k < DEPTH_K; k++)
         for (int j = 0; j < COLS; j++) b_t[k][j] = (k == j) ? 1 : 0;
      run_tile("R4", 0, 0, 1);

      // R3: every product overflows DATA_W
      for (int i = 0; i < ROWS; i++)
         for (int k = 0; k < DEPTH_K; k++) a_t[i][k] = '1;
      for (int k = 0; k < DEPTH_K; k++)
         for (int j = 0; j < COLS; j++) b_t[k][j] = '1;
      run_tile("R3", 0, 1, 0);

      // R6: random tiles under random flow control
      for (int t = 0; t < 5; t++) begin
         for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < DEPTH_K; k++) a_t[i][k] = DATA_W'($urandom);
         for (int k = 0; k < DEPTH_K; k++)
            for (int j = 0; j < COLS; j++) b_t[k][j] = DATA_W'($urandom);
         run_tile((t % 2 == 0) ? "R6" : "R3", t != 0, t != 1, t == 4);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule